// File: doc/BRIEF.md
# Console Keyboard and Display Register Block

This block is a small bus peripheral that links a processor to a character keyboard and a character display through four 16-bit registers. The keyboard side receives a one-cycle valid pulse with an 8-bit code. The block latches the code and raises a ready flag, and software polls that flag or takes an interrupt. The display side works the other way round. Software writes a character, the block presents it on its device outputs with a one-cycle strobe, and the display later pulses a done input to show it can take another character.

Both devices use a ready-bit handshake, and the ready bits change only as a side effect of data accesses. While a keyboard character is waiting to be read, new keys are locked out. While the display is busy, writes to it are discarded. Each device also has a software-writable interrupt enable, and the block raises an interrupt request whenever that device's ready bit and enable bit are both set.

Bus reads are combinational. `bus_rdata` reflects the addressed register in the same cycle that `bus_rd` is high, and any side effect of the access takes place at the next rising clock edge.

Top module: `conio_mmio`

## Requirements
- R1: Register addresses are fixed. Keyboard status is at 0xFE00, keyboard data at 0xFE02, display status at 0xFE04 and display data at 0xFE06. Any other address reads as zero. Writes to any other address, and writes to keyboard data, change nothing. Display data reads as zero.
- R2: When a key pulse arrives while keyboard ready is 0, the code is stored and keyboard ready becomes 1 at the next edge. Keyboard data then reads as the code in bits [7:0], with bits [15:8] zero.
- R3: While keyboard ready is 1, incoming key pulses are ignored, and the stored code keeps its value.
- R4: A read of keyboard data clears keyboard ready at the next edge. The next key pulse is then accepted.
- R5: A status read returns the ready flag in bit 15 and the interrupt enable in bit 14, with all other bits zero. A status write changes only the enable, which is loaded from bit 14 of the write data.
- R6: A display-data write while display ready is 1 clears display ready. In the cycle after the write edge, it drives write-data bits [7:0] on `disp_char` and pulses `disp_wr` high for exactly one cycle.
- R7: A display-data write while display ready is 0 is discarded. No strobe occurs, and `disp_char` keeps its value.
- R8: A `disp_done` pulse while display ready is 0 sets display ready at the next edge.
- R9: `kbd_irq` equals keyboard ready AND keyboard enable, and `disp_irq` equals display ready AND display enable.
- R10: After reset, keyboard ready is 0, display ready is 1, both enables are 0, `disp_wr` is 0 and both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Bus word address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational while bus_rd is high |
| key_valid | input | 1 | One-cycle pulse marking a new key code |
| key_code | input | 8 | Key code qualified by key_valid |
| disp_done | input | 1 | Display finished the previous character |
| disp_char | output | 8 | Character handed to the display |
| disp_wr | output | 1 | One-cycle strobe qualifying disp_char |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |

## Verification
On every clocked cycle the embedded properties check the transitions of the ready flags: a key is captured only when ready is clear, a held code stays stable, a data read releases the lockout, and display writes are either accepted with a strobe or dropped without one. The address map, the layout of the status words, the interrupt gating and the reset values are visible only at the bus ports. The bench's scenarios cover these through scored reads and interrupt samples. Those scenarios also show that a locked-out key or a dropped display write never reaches the outputs later.

// File: rtl/conio_pkg.sv
// conio_pkg: shared constants for the console register block.
// Assumes 16-bit registers spaced two address units apart.
package conio_pkg;
    localparam int WORD_W   = 16;
    localparam int CHAR_W   = 8;
    localparam int NREG     = 4;
    localparam int RDY_BIT  = 15;
    localparam int IE_BIT   = 14;
    // Register slots, in address order from the base
    localparam int IDX_KSTAT = 0;
    localparam int IDX_KDATA = 1;
    localparam int IDX_DSTAT = 2;
    localparam int IDX_DDATA = 3;
endpackage

// File: rtl/conio_decode.sv
// conio_decode: turns an address plus strobes into one-hot slot hits.
// Assumes full-width address compare; slot i sits at BASE + i*STRIDE.
module conio_decode #(
    parameter int ADDR_W = 16,
    parameter int NREG   = 4,
    parameter int STRIDE = 2,
    parameter logic [ADDR_W-1:0] BASE = 16'hFE00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic [NREG-1:0]   rd_hit,
    output logic [NREG-1:0]   wr_hit
);
    // One comparator per register slot
    for (genvar i = 0; i < NREG; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(int'(BASE) + i * STRIDE);
        assign rd_hit[i] = rd && (addr == SLOT_ADDR);
        assign wr_hit[i] = wr && (addr == SLOT_ADDR);
    end
endmodule

// File: rtl/conio_kbd_port.sv
// conio_kbd_port: keyboard ready flag, enable and latched code.
// Assumes key_valid is a single-cycle pulse; a held key is dropped.
module conio_kbd_port #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_code,
    input  logic              stat_wr,
    input  logic              ie_in,
    input  logic              data_rd,
    output logic              ready,
    output logic              ie,
    output logic [CHAR_W-1:0] code
);
    // Enable register, written through the status slot
    always_ff @(posedge clk) begin
        if (!rst_n)       ie <= 1'b0;
        else if (stat_wr) ie <= ie_in;
    end

    // Ready handshake: capture when idle, release on data read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
            code  <= '0;
        end else if (ready) begin
            if (data_rd) ready <= 1'b0;
        end else if (key_valid) begin
            ready <= 1'b1;
            code  <= key_code;
        end
    end

    AST_KBD_TAKE: assert property (@(posedge clk) disable iff (!rst_n) (!ready && key_valid) |=> (ready && code == $past(key_code))) else $error("key not captured"); // R2
    AST_KBD_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (ready && !data_rd) |=> (ready && $stable(code))) else $error("locked key changed"); // R3
    AST_KBD_FREE: assert property (@(posedge clk) disable iff (!rst_n) (ready && data_rd) |=> !ready) else $error("read did not release"); // R4
endmodule

// File: rtl/conio_disp_port.sv
// conio_disp_port: display ready flag, enable, character and strobe.
// Assumes disp_done arrives only after a character was sent.
module conio_disp_port #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic              ie_in,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              done,
    output logic              ready,
    output logic              ie,
    output logic [CHAR_W-1:0] disp_char,
    output logic              disp_wr
);
    // Enable register, written through the status slot
    always_ff @(posedge clk) begin
        if (!rst_n)       ie <= 1'b0;
        else if (stat_wr) ie <= ie_in;
    end

    // Ready handshake: send on write when free, rearm on done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready     <= 1'b1;
            disp_char <= '0;
            disp_wr   <= 1'b0;
        end else begin
            disp_wr <= 1'b0;
            if (ready) begin
                if (data_wr) begin
                    ready     <= 1'b0;
                    disp_char <= wchar;
                    disp_wr   <= 1'b1;
                end
            end else if (done) begin
                ready <= 1'b1;
            end
        end
    end

    AST_DISP_SEND: assert property (@(posedge clk) disable iff (!rst_n) (ready && data_wr) |=> (disp_wr && !ready && disp_char == $past(wchar))) else $error("write not sent"); // R6
    AST_DISP_DROP: assert property (@(posedge clk) disable iff (!rst_n) (!ready && data_wr) |=> !disp_wr) else $error("busy write leaked"); // R7
    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ready && !done) |=> (!ready && $stable(disp_char))) else $error("busy state changed"); // R7
    AST_DISP_DONE: assert property (@(posedge clk) disable iff (!rst_n) (!ready && done) |=> ready) else $error("done ignored"); // R8
endmodule

// File: rtl/conio_mmio.sv
// conio_mmio: keyboard/display register block on a simple strobe bus.
// Assumes one-cycle rd/wr strobes; read data is combinational.
module conio_mmio
    import conio_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_code,
    input  logic              disp_done,
    output logic [CHAR_W-1:0] disp_char,
    output logic              disp_wr,
    output logic              kbd_irq,
    output logic              disp_irq
);
    localparam int STRIDE = 2;

    logic [NREG-1:0]   rd_hit, wr_hit;
    logic              k_ready, k_ie, d_ready, d_ie;
    logic [CHAR_W-1:0] k_code;

    conio_decode #(.ADDR_W(ADDR_W), .NREG(NREG), .STRIDE(STRIDE), .BASE(BASE)) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .rd_hit(rd_hit), .wr_hit(wr_hit)
    );

    conio_kbd_port #(.CHAR_W(CHAR_W)) u_kbd (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .stat_wr(wr_hit[IDX_KSTAT]), .ie_in(bus_wdata[IE_BIT]),
        .data_rd(rd_hit[IDX_KDATA]), .ready(k_ready), .ie(k_ie), .code(k_code)
    );

    conio_disp_port #(.CHAR_W(CHAR_W)) u_disp (
        .clk(clk), .rst_n(rst_n), .stat_wr(wr_hit[IDX_DSTAT]), .ie_in(bus_wdata[IE_BIT]),
        .data_wr(wr_hit[IDX_DDATA]), .wchar(bus_wdata[CHAR_W-1:0]), .done(disp_done),
        .ready(d_ready), .ie(d_ie), .disp_char(disp_char), .disp_wr(disp_wr)
    );

    // Read mux: status words, zero-extended key code, zero elsewhere
    always_comb begin
        bus_rdata = '0;
        if (rd_hit[IDX_KSTAT]) begin
            bus_rdata[RDY_BIT] = k_ready;
            bus_rdata[IE_BIT]  = k_ie;
        end
        if (rd_hit[IDX_KDATA]) bus_rdata[CHAR_W-1:0] = k_code;
        if (rd_hit[IDX_DSTAT]) begin
            bus_rdata[RDY_BIT] = d_ready;
            bus_rdata[IE_BIT]  = d_ie;
        end
    end

    // Interrupt requests gated by the per-device enable
    assign kbd_irq  = k_ready & k_ie;
    assign disp_irq = d_ready & d_ie;
endmodule

// File: tb/sim_conio_mmio.sv
module sim_conio_mmio;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        key_valid = 1'b0;
    logic [7:0]  key_code = '0;
    logic        disp_done = 1'b0;
    logic [7:0]  disp_char;
    logic        disp_wr, kbd_irq, disp_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [15:0] rd_exp_q[$];
    string       rd_tag_q[$];
    logic [7:0]  ch_exp_q[$];
    string       ch_tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    conio_mmio u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_valid(key_valid), .key_code(key_code),
        .disp_done(disp_done), .disp_char(disp_char), .disp_wr(disp_wr),
        .kbd_irq(kbd_irq), .disp_irq(disp_irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver tasks: stimulus plus expectations pushed to the scoreboard
    task automatic bus_read(input logic [15:0] a, input logic [15:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic disp_write(input logic [15:0] d, input bit accepted, input string tag);
        if (accepted) begin
            ch_exp_q.push_back(d[7:0]); ch_tag_q.push_back(tag);
        end
        bus_write(16'hFE06, d);
    endtask

    task automatic key_pulse(input logic [7:0] c);
        @(posedge clk); #1;
        key_valid = 1'b1; key_code = c;
        @(posedge clk); #1;
        key_valid = 1'b0; key_code = 8'hEE;
    endtask

    task automatic done_pulse();
        @(posedge clk); #1;
        disp_done = 1'b1;
        @(posedge clk); #1;
        disp_done = 1'b0;
    endtask

    // Monitor: pops expectations as reads and display strobes occur
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            if (rd_exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R1 actual=unscored read expected=none");
            end else begin
                check(rd_tag_q.pop_front(), bus_rdata, rd_exp_q.pop_front());
            end
        end
        if (rst_n && disp_wr) begin
            if (ch_exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R7 actual=strobe char=%h expected=no strobe", disp_char);
            end else begin
                check(ch_tag_q.pop_front(), {8'h00, disp_char}, {8'h00, ch_exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R10 kbd_irq", {15'b0, kbd_irq}, 16'h0);
        check("R10 disp_irq", {15'b0, disp_irq}, 16'h0);
        check("R10 disp_wr", {15'b0, disp_wr}, 16'h0);
        bus_read(16'hFE00, 16'h0000, "R10 kbd status");
        bus_read(16'hFE04, 16'h8000, "R10 disp status");

        // Keyboard capture, lockout and release
        key_pulse(8'h41);
        bus_read(16'hFE00, 16'h8000, "R2 kbd ready");
        key_pulse(8'h42);
        bus_read(16'hFE02, 16'h0041, "R3 locked code");
        bus_read(16'hFE00, 16'h0000, "R4 ready cleared");
        key_pulse(8'h7A);
        bus_read(16'hFE02, 16'h007A, "R4 input re-enabled");

        // Status write touches only the enable
        bus_write(16'hFE00, 16'hFFFF);
        bus_read(16'hFE00, 16'h4000, "R5 only enable written");
        @(negedge clk);
        check("R9 kbd_irq idle", {15'b0, kbd_irq}, 16'h0);
        key_pulse(8'h31);
        @(negedge clk);
        check("R9 kbd_irq raised", {15'b0, kbd_irq}, 16'h1);
        bus_read(16'hFE00, 16'hC000, "R5 status layout");
        bus_read(16'hFE02, 16'h0031, "R2 code zero-extended");
        @(negedge clk);
        check("R9 kbd_irq dropped", {15'b0, kbd_irq}, 16'h0);
        bus_write(16'hFE00, 16'h0000);

        // Display send, busy drop, rearm
        disp_write(16'h1248, 1'b1, "R6 char sent");
        bus_read(16'hFE04, 16'h0000, "R6 ready cleared");
        disp_write(16'h0055, 1'b0, "R7");
        bus_read(16'hFE04, 16'h0000, "R7 still busy");
        done_pulse();
        bus_read(16'hFE04, 16'h8000, "R8 ready set by done");
        disp_write(16'h0063, 1'b1, "R7 later char not stale");
        bus_write(16'hFE04, 16'h4000);
        @(negedge clk);
        check("R9 disp_irq busy", {15'b0, disp_irq}, 16'h0);
        done_pulse();
        @(negedge clk);
        check("R9 disp_irq raised", {15'b0, disp_irq}, 16'h1);
        bus_read(16'hFE04, 16'hC000, "R5 disp status layout");

        // Address map edges
        bus_read(16'hFE08, 16'h0000, "R1 unmapped high");
        bus_read(16'hFE01, 16'h0000, "R1 odd address");
        bus_read(16'hFE06, 16'h0000, "R1 display data reads zero");
        bus_write(16'hFE02, 16'hFFFF);
        bus_write(16'hFE08, 16'hFFFF);
        bus_read(16'hFE00, 16'h0000, "R1 stray writes ignored");
        bus_read(16'hFE04, 16'hC000, "R1 disp status untouched");

        repeat (4) @(posedge clk);
        check("R6 all strobes seen", 16'(ch_exp_q.size()), 16'h0);
        check("R1 all reads scored", 16'(rd_exp_q.size()), 16'h0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule